// File: doc/BRIEF.md
# Dual-Host Secondary Interrupt Controller

This block collects up to eight interrupt sources and reports them to two independent host masters. Each source input passes through a two-flop synchroniser. A programmable edge detector then turns a rising edge, a falling edge or either edge into an event. One edge-configuration register holds the trigger selection for all sources, and both hosts share it.

Each host has its own status register, its own mask register and its own active-low interrupt output. An event sets the status bit of every host that has that source unmasked. If an event arrives while a status bit is already set, it is held in a one-deep pending slot. The pending event sets the status bit again as soon as the first one is acknowledged.

A control bit selects how hosts acknowledge: a read of a status register can clear the bits it returns, or software can clear bits by writing ones to them. All registers are reached through a small synchronous register port. Read data is returned one cycle after the read strobe.

Top module: `irqc_dual_host`

## Requirements
- R1: After reset, both status registers read 0x00, both mask registers read all ones in their valid bits (0x3F for six sources), the edge-configuration bytes and the control register read 0x00, and both interrupt outputs are high.
- R2: Source i is configured by a 2-bit field in edge byte i/4 at bit offset (i mod 4)*2. The upper bit of the field enables rising-edge detection, the lower bit enables falling-edge detection, and setting both triggers on either edge.
- R3: A source whose two edge bits are both clear never sets status on any host, even when it is unmasked.
- R4: A mask bit of 1 stops its source from setting that host's status. The two hosts' masks act independently.
- R5: An event sets the status bit on both unmasked hosts in the same cycle. Counting the rising clock edges that sample a new source level, the status bit is set at the third edge and the interrupt output falls at the fourth.
- R6: With the control bit set (control bit 0 = 1), reading a status register returns its bits and clears exactly those bits, and writes to status registers have no effect.
- R7: With control bit 0 = 0, writing a 1 to a status bit clears it, 0 bits are left alone, and reads do not clear anything.
- R8: A second event that arrives while a status bit is set is held: after the first acknowledgement the bit reads 1 again. A third event arriving while one is already held is dropped, so two acknowledgements always empty the bit.
- R9: A host's interrupt output is low exactly when some status bit of that host is set and its mask bit is 0, and it follows a change of status or mask one cycle later.
- R10: Status and mask bits at or above the source count, and edge bits at or above twice the source count, read as 0 whatever was written to them.
- R11: A clear-on-read that falls in the same cycle as a new event on the same source returns the old status and leaves the bit set for the new event.
- R12: The register addresses are: 0 host-0 status, 1 host-0 mask, 2 host-1 status, 3 host-1 mask, 4 and 5 edge bytes 0 and 1, 6 control (bit 0 selects clear-on-read). Read data is registered one cycle after the read strobe and holds until the next read. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NSRC | Asynchronous interrupt source levels |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| irq0_n_o | output | 1 | Host 0 interrupt, active low |
| irq1_n_o | output | 1 | Host 1 interrupt, active low |

## Verification
A source change takes three clock edges to reach status and a fourth to reach the interrupt output. Read data appears one edge after its strobe, and an acknowledgement or mask write moves the interrupt output on the edge after it lands. The bench drives inputs and samples outputs at falling clock edges. It checks the interrupt outputs at the exact negedge where each of these latencies expires, including one negedge early to show the output has not moved yet. A behavioural model that counts outstanding events per host and source is compared with both interrupt outputs and the read data on every clock. The coincident read-and-event case is timed so that the read strobe is sampled on the same edge at which the event sets status.

// File: rtl/irqc_pkg.sv
// Shared register map for the dual-host interrupt controller.
package irqc_pkg;
    localparam int ADR_ST0   = 0;
    localparam int ADR_MK0   = 1;
    localparam int ADR_ST1   = 2;
    localparam int ADR_MK1   = 3;
    localparam int ADR_EDGE  = 4;
    localparam int ADR_CTRL  = 6;
    localparam int CTRL_COR  = 0;
    localparam int NUM_HOSTS = 2;
endpackage

// File: rtl/irqc_edge_unit.sv
// Synchronises each source with two flops and flags configured edges.
// Assumes sources are low during reset; cfg holds {rise,fall} per source.
module irqc_edge_unit #(
    parameter int NSRC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [2*NSRC-1:0] cfg_i,
    output logic [NSRC-1:0]   ev_o
);
    logic [NSRC-1:0] meta_q, sync_q, prev_q;

    // Two-flop synchroniser plus one history stage for edge compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= src_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_det
        // Event when the enabled direction of change is seen
        assign ev_o[i] = (sync_q[i] & ~prev_q[i] & cfg_i[2*i+1])
                       | (~sync_q[i] & prev_q[i] & cfg_i[2*i]);
    end
endmodule

// File: rtl/irqc_host_view.sv
// One host's status, mask and one-deep pending slot, with its interrupt.
// Assumes ev_i is a single-cycle event pulse per source.
module irqc_host_view #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_i,
    input  logic            cor_i,
    input  logic            st_rd_i,
    input  logic            st_wr_i,
    input  logic            mk_wr_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] st_o,
    output logic [NSRC-1:0] mk_o,
    output logic            irq_n_o
);
    logic [NSRC-1:0] pend_q, ev_en, clr, keep, st_d, pend_d;

    // Next status and pending state from acks and unmasked events
    always_comb begin
        ev_en  = ev_i & ~mk_o;
        clr    = (st_rd_i && cor_i)  ? st_o :
                 (st_wr_i && !cor_i) ? wdata_i : '0;
        keep   = st_o & ~clr;
        st_d   = keep | ev_en | pend_q;
        pend_d = (keep & (pend_q | ev_en)) | (~keep & ev_en & pend_q);
    end

    // State registers; masks reset to all ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_o    <= '0;
            pend_q  <= '0;
            mk_o    <= '1;
            irq_n_o <= 1'b1;
        end else begin
            st_o    <= st_d;
            pend_q  <= pend_d;
            if (mk_wr_i) mk_o <= wdata_i;
            irq_n_o <= ~|(st_o & ~mk_o);
        end
    end

    AST_PEND_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~st_o) == '0); // R8
    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|mk_o) |=> ((st_o & ~$past(st_o)) & $past(mk_o & ~pend_q)) == '0); // R4
    AST_SET_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~st_o)) |=> ((st_o & ~$past(st_o)) & ~$past(ev_i | pend_q)) == '0); // R5
    AST_IRQ_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o == '0) |=> irq_n_o); // R9
    AST_COR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_i && st_rd_i) |=>
        (st_o & $past(st_o & ~(ev_i & ~mk_o) & ~pend_q)) == '0); // R6
endmodule

// File: rtl/irqc_dual_host.sv
// Dual-host secondary interrupt controller: register port, shared edge
// configuration, acknowledge-mode control and two host views.
// Assumes NSRC <= DATA_W and at most two edge bytes in the address map.
module irqc_dual_host
    import irqc_pkg::*;
#(
    parameter int NSRC   = 6,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq0_n_o,
    output logic              irq1_n_o
);
    localparam int EDGE_W     = 2 * NSRC;
    localparam int EDGE_BYTES = (EDGE_W + DATA_W - 1) / DATA_W;
    localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << NSRC) - 1);

    logic [EDGE_W-1:0]            edge_cfg;
    logic [EDGE_BYTES*DATA_W-1:0] edge_pad;
    logic                         cor_q;
    logic [NSRC-1:0]              ev;
    logic [NSRC-1:0]              st_v [NUM_HOSTS];
    logic [NSRC-1:0]              mk_v [NUM_HOSTS];
    logic                         irq_v [NUM_HOSTS];
    logic [DATA_W-1:0]            rd_next;

    assign edge_pad = (EDGE_BYTES*DATA_W)'(edge_cfg);

    // Shared edge configuration and acknowledge-mode bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cfg <= '0;
            cor_q    <= 1'b0;
        end else if (wr_en_i) begin
            for (int j = 0; j < EDGE_W; j++) begin
                if (addr_i == ADDR_W'(ADR_EDGE + j / DATA_W))
                    edge_cfg[j] <= wdata_i[j % DATA_W];
            end
            if (addr_i == ADDR_W'(ADR_CTRL)) cor_q <= wdata_i[CTRL_COR];
        end
    end

    irqc_edge_unit #(.NSRC(NSRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .cfg_i (edge_cfg),
        .ev_o  (ev)
    );

    for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
        irqc_host_view #(.NSRC(NSRC)) u_view (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_i    (ev),
            .cor_i   (cor_q),
            .st_rd_i (rd_en_i && addr_i == ADDR_W'(ADR_ST0 + 2*h)),
            .st_wr_i (wr_en_i && addr_i == ADDR_W'(ADR_ST0 + 2*h)),
            .mk_wr_i (wr_en_i && addr_i == ADDR_W'(ADR_MK0 + 2*h)),
            .wdata_i (wdata_i[NSRC-1:0]),
            .st_o    (st_v[h]),
            .mk_o    (mk_v[h]),
            .irq_n_o (irq_v[h])
        );
    end

    assign irq0_n_o = irq_v[0];
    assign irq1_n_o = irq_v[1];

    // Read multiplexer over the register map
    always_comb begin
        rd_next = '0;
        for (int h = 0; h < NUM_HOSTS; h++) begin
            if (addr_i == ADDR_W'(ADR_ST0 + 2*h)) rd_next[NSRC-1:0] = st_v[h];
            if (addr_i == ADDR_W'(ADR_MK0 + 2*h)) rd_next[NSRC-1:0] = mk_v[h];
        end
        for (int b = 0; b < EDGE_BYTES; b++) begin
            if (addr_i == ADDR_W'(ADR_EDGE + b)) rd_next = edge_pad[b*DATA_W +: DATA_W];
        end
        if (addr_i == ADDR_W'(ADR_CTRL)) rd_next[CTRL_COR] = cor_q;
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_next;
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i < ADDR_W'(ADR_EDGE)) |=> (rdata_o & ~LOW_MASK) == '0); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o)); // R12
endmodule

// File: tb/irqc_dual_host_tb.sv
`timescale 1ns/1ps
module irqc_dual_host_tb;
    localparam int N = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata;
    logic       irq0_n, irq1_n;

    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irqc_dual_host u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
        .wdata_i(wdata), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .rdata_o(rdata), .irq0_n_o(irq0_n), .irq1_n_o(irq1_n)
    );

    // Behavioural reference: outstanding-event counts per host and source
    logic [N-1:0] m_s1, m_s2, m_s3;
    int           m_cnt [2][N];
    logic [N-1:0] m_mk [2];
    logic [11:0]  m_edge;
    logic         m_cor;
    logic [7:0]   m_rdata;
    logic         m_irq [2];

    function automatic logic [N-1:0] m_stat(int h);
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = (m_cnt[h][i] > 0);
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
            for (int h = 0; h < 2; h++) begin
                m_mk[h] = '1; m_irq[h] = 1'b1;
                for (int i = 0; i < N; i++) m_cnt[h][i] = 0;
            end
            m_edge = '0; m_cor = 1'b0; m_rdata = '0;
        end else begin
            logic [N-1:0] evt;
            logic [7:0]   rv;
            for (int i = 0; i < N; i++)
                evt[i] = (m_s2[i] && !m_s3[i] && m_edge[2*i+1]) ||
                         (!m_s2[i] && m_s3[i] && m_edge[2*i]);
            case (addr)
                3'd0: rv = {2'b0, m_stat(0)};
                3'd1: rv = {2'b0, m_mk[0]};
                3'd2: rv = {2'b0, m_stat(1)};
                3'd3: rv = {2'b0, m_mk[1]};
                3'd4: rv = m_edge[7:0];
                3'd5: rv = {4'b0, m_edge[11:8]};
                3'd6: rv = {7'b0, m_cor};
                default: rv = 8'h00;
            endcase
            if (rd_en) m_rdata = rv;
            for (int h = 0; h < 2; h++) begin
                m_irq[h] = ~|(m_stat(h) & ~m_mk[h]);
                for (int i = 0; i < N; i++) begin
                    bit ack;
                    ack = (m_cor && rd_en && addr == 3'(2*h)) ||
                          (!m_cor && wr_en && addr == 3'(2*h) && wdata[i]);
                    if (ack && m_cnt[h][i] > 0) m_cnt[h][i]--;
                    if (evt[i] && !m_mk[h][i] && m_cnt[h][i] < 2) m_cnt[h][i]++;
                end
            end
            if (wr_en) begin
                if (addr == 3'd1) m_mk[0] = wdata[N-1:0];
                if (addr == 3'd3) m_mk[1] = wdata[N-1:0];
                if (addr == 3'd4) m_edge[7:0] = wdata;
                if (addr == 3'd5) m_edge[11:8] = wdata[3:0];
                if (addr == 3'd6) m_cor = wdata[0];
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = src;
        end
    end

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (irq0_n !== m_irq[0] || irq1_n !== m_irq[1] || rdata !== m_rdata) begin
                fails++;
                $display("FAIL R9/R12 model: irq0=%0b irq1=%0b rdata=%0h expected irq0=%0b irq1=%0b rdata=%0h",
                         irq0_n, irq1_n, rdata, m_irq[0], m_irq[1], m_rdata);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic rdchk(logic [2:0] a, logic [7:0] e, string tag);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    task automatic set_src(logic [N-1:0] v);
        @(negedge clk); src = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk(3'd0, 8'h00, "R1 status0");
        rdchk(3'd1, 8'h3F, "R1 mask0");
        rdchk(3'd2, 8'h00, "R1 status1");
        rdchk(3'd3, 8'h3F, "R1 mask1");
        rdchk(3'd4, 8'h00, "R1 edge0");
        rdchk(3'd6, 8'h00, "R1 ctrl");
        chk("R1 irq0", irq0_n, 1);
        chk("R1 irq1", irq1_n, 1);
        rdchk(3'd7, 8'h00, "R12 unmapped");

        // R10 upper mask bits, R12 map
        wr(3'd1, 8'hFF);
        rdchk(3'd1, 8'h3F, "R10 mask upper");
        wr(3'd1, 8'h00);
        rdchk(3'd1, 8'h00, "R12 mask0 write");

        // R3 no edge bits: no status
        set_src(6'h01); idle(5);
        rdchk(3'd0, 8'h00, "R3 no trigger");
        chk("R3 irq0", irq0_n, 1);
        set_src(6'h00); idle(5);

        // R5 latency, R4 host1 masked, R7 W1C
        wr(3'd4, 8'h02);
        set_src(6'h01);
        idle(3); chk("R5 irq early", irq0_n, 1);
        idle(1); chk("R5 irq due", irq0_n, 0);
        rdchk(3'd0, 8'h01, "R5 status0");
        rdchk(3'd2, 8'h00, "R4 status1 masked");
        chk("R4 irq1", irq1_n, 1);
        rdchk(3'd0, 8'h01, "R7 read no clear");
        wr(3'd0, 8'h00);
        rdchk(3'd0, 8'h01, "R7 zero write");
        wr(3'd0, 8'h01);
        rdchk(3'd0, 8'h00, "R7 one write");
        chk("R9 irq0 release", irq0_n, 1);

        // R2 falling on source 1, both edges on source 4
        wr(3'd4, 8'h06);
        set_src(6'h03); idle(5);
        rdchk(3'd0, 8'h00, "R2 src1 rise off");
        set_src(6'h01); idle(5);
        rdchk(3'd0, 8'h02, "R2 src1 fall");
        wr(3'd0, 8'h3F);
        wr(3'd5, 8'h03);
        set_src(6'h11); idle(5);
        rdchk(3'd0, 8'h10, "R2 src4 rise");
        wr(3'd0, 8'h10);
        set_src(6'h01); idle(5);
        rdchk(3'd0, 8'h10, "R2 src4 fall");
        wr(3'd0, 8'h3F);
        wr(3'd5, 8'hFF);
        rdchk(3'd5, 8'h0F, "R10 edge upper");
        wr(3'd5, 8'h00);

        // R5 both hosts together
        wr(3'd3, 8'h00);
        set_src(6'h00); idle(5);
        set_src(6'h01);
        idle(3); chk("R5 both early", {irq0_n, irq1_n}, 2'b11);
        idle(1); chk("R5 both due", {irq0_n, irq1_n}, 2'b00);
        rdchk(3'd0, 8'h01, "R5 host0");
        rdchk(3'd2, 8'h01, "R5 host1");

        // R9 mask follows one cycle later
        wr(3'd1, 8'h3F);
        chk("R9 mask not yet", irq0_n, 0);
        idle(1); chk("R9 masked", irq0_n, 1);
        wr(3'd1, 8'h00);
        idle(1); chk("R9 unmasked", irq0_n, 0);

        // R6 clear-on-read
        wr(3'd6, 8'h01);
        rdchk(3'd6, 8'h01, "R12 ctrl");
        rdchk(3'd0, 8'h01, "R6 read returns");
        rdchk(3'd0, 8'h00, "R6 read cleared");
        wr(3'd2, 8'h01);
        rdchk(3'd2, 8'h01, "R6 write ignored");
        rdchk(3'd2, 8'h00, "R6 host1 cleared");
        idle(1);
        chk("R6 irqs idle", {irq0_n, irq1_n}, 2'b11);

        // R8 pending: three events, two acks empty it
        wr(3'd6, 8'h00);
        for (int k = 0; k < 3; k++) begin
            set_src(6'h00); idle(5);
            set_src(6'h01); idle(5);
        end
        rdchk(3'd0, 8'h01, "R8 first");
        wr(3'd0, 8'h01);
        rdchk(3'd0, 8'h01, "R8 held event");
        wr(3'd0, 8'h01);
        rdchk(3'd0, 8'h00, "R8 third dropped");
        wr(3'd2, 8'h01); wr(3'd2, 8'h01);
        rdchk(3'd2, 8'h00, "R8 host1 empty");

        // R11 clear-on-read coinciding with a new event
        wr(3'd6, 8'h01);
        set_src(6'h00); idle(5);
        set_src(6'h01); idle(5);
        set_src(6'h00); idle(5);
        set_src(6'h01);
        @(negedge clk);
        @(negedge clk); addr = 3'd0; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rdata;
        chk("R11 old value", v, 8'h01);
        rdchk(3'd0, 8'h01, "R11 new kept");
        rdchk(3'd0, 8'h00, "R11 then clear");

        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule